// File: doc/BRIEF.md
# Exponent-Mantissa Limit Comparator with Fault Count

This block watches a stream of conversion results, each a 16-bit word made of a 4-bit exponent (bits 15:12) and a 12-bit mantissa (bits 11:0). The value of a word is the mantissa multiplied by two to the power of the exponent. Every new result is converted to that linear value and compared against an upper and a lower threshold given in the same word format. Because both sides are linearised first, a threshold and a result written with different exponents still compare correctly.

Each side of the comparison has its own counter of consecutive out-of-limit results. A flag goes high once the count reaches the number chosen by a 2-bit persistence code, and a result that is back inside the limit clears both the counter and the flag for that side. The block also registers a readback copy of the result, with the exponent optionally forced to zero when the range is set by hand. It keeps a conversion-ready flag that sets on every result and clears on configuration traffic.

Top module: `lcmp_limit_monitor`

## Requirements
- R1: The linear value of a word is mantissa << exponent, computed 23 bits wide; exponent codes 12 to 15 are treated as 11. All comparisons use linear values, so words with different exponents but the same linear value are equal.
- R2: A result is a high fault when its linear value is strictly greater than that of `hi_limit`; a result equal to the limit is not a fault.
- R3: A result is a low fault when its linear value is strictly less than that of `lo_limit`; a result equal to the limit is not a fault.
- R4: `fault_cnt` selects how many consecutive faults raise a flag: 00 needs 1, 01 needs 2, 10 needs 4, 11 needs 8. The flag is visible in the cycle after the `res_valid` cycle of the result that reaches the count, and stays high while further faults arrive on that side.
- R5: A result that is not a fault on one side resets that side's consecutive count to zero and clears that side's flag in the following cycle.
- R6: On `res_valid`, `res_readback` takes `res_word`, except that bits 15:12 read 0 when `mask_exp` is 1 and `range_code` is below 4'hC in that cycle. The limit comparisons always use the unmasked word.
- R7: `conv_ready` is 1 in the cycle after any `res_valid`; a result wins over a clear request in the same cycle.
- R8: Without a result, `conv_ready` clears after a cycle with `cfg_rd` = 1 or with `cfg_wr` = 1 and `cfg_wr_mode` not 00; `cfg_wr` with `cfg_wr_mode` = 00 leaves it unchanged.
- R9: While reset is active and after its release, `flag_hi`, `flag_lo`, `conv_ready` and `res_readback` are 0.
- R10: In cycles without `res_valid`, `flag_hi`, `flag_lo` and `res_readback` hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| res_valid | input | 1 | One-cycle strobe: `res_word` holds a new result |
| res_word | input | 16 | Result, exponent in 15:12, mantissa in 11:0 |
| lo_limit | input | 16 | Lower threshold, same format |
| hi_limit | input | 16 | Upper threshold, same format |
| fault_cnt | input | 2 | Consecutive-fault persistence code |
| mask_exp | input | 1 | Force readback exponent to zero in manual range |
| range_code | input | 4 | Range setting; 4'hC and above mean automatic |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wr_mode | input | 2 | Mode field of the word being written |
| res_readback | output | 16 | Registered, optionally masked result |
| flag_hi | output | 1 | High-limit persistence flag |
| flag_lo | output | 1 | Low-limit persistence flag |
| conv_ready | output | 1 | Conversion-ready flag |

## Verification
Directed cases place results exactly on each limit and at limits written with a different exponent for the same linear value, which separates a strict from an inclusive comparison and a linear from a raw-bit comparison. Runs of faults broken by one in-limit result at each persistence code tell a counter that resets apart from one that only saturates. A masked word whose hidden exponent pushes it over the limit shows whether the comparison uses the masked or unmasked value. Random results drawn around randomly chosen limits, mixed with configuration strobes, exercise both counters and the ready flag against a bench model.

// File: rtl/lcmp_pkg.sv
package lcmp_pkg;
  parameter int unsigned MANT_W  = 12;
  parameter int unsigned EXP_W   = 4;
  parameter int unsigned EXP_TOP = 11;
  parameter int unsigned WORD_W  = EXP_W + MANT_W;
  parameter int unsigned LIN_W   = MANT_W + EXP_TOP;
  parameter int unsigned FC_W    = 2;
  parameter int unsigned MODE_W  = 2;

  localparam logic [EXP_W-1:0]  AUTO_RANGE = 4'hC;
  localparam logic [MODE_W-1:0] MODE_OFF   = 2'b00;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LIN_W-1:0]  lin_t;
endpackage

// File: rtl/lcmp_rst_sync.sv
module lcmp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic sync_rst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/lcmp_linearize.sv
module lcmp_linearize
  import lcmp_pkg::*;
(
  input  word_t word_in,
  output lin_t  lin_out
);
  logic [EXP_W-1:0]  exp_f;
  logic [MANT_W-1:0] mant_f;
  logic [EXP_W-1:0]  exp_eff;

  always_comb begin
    exp_f   = word_in[WORD_W-1:MANT_W];
    mant_f  = word_in[MANT_W-1:0];
    exp_eff = (exp_f > EXP_W'(EXP_TOP)) ? EXP_W'(EXP_TOP) : exp_f;
    lin_out = LIN_W'(mant_f) << exp_eff;
  end
endmodule

// File: rtl/lcmp_fault_track.sv
module lcmp_fault_track
  import lcmp_pkg::*;
#(
  parameter int unsigned CODE_W = FC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              fault,
  input  logic [CODE_W-1:0] fc_code,
  output logic              flag
);
  localparam int unsigned MAX_RUN = 1 << ((1 << CODE_W) - 1);
  localparam int unsigned CNT_W   = $clog2(MAX_RUN) + 1;

  logic [CNT_W-1:0] run_q, run_d;
  logic             flag_q, flag_d;
  logic [CNT_W-1:0] need;

  always_comb begin
    need   = CNT_W'(1) << fc_code;
    run_d  = run_q;
    flag_d = flag_q;
    if (valid) begin
      if (fault) begin
        run_d  = (run_q >= CNT_W'(MAX_RUN)) ? CNT_W'(MAX_RUN) : run_q + CNT_W'(1);
        flag_d = (run_d >= need);
      end else begin
        run_d  = '0;
        flag_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      flag_q <= 1'b0;
    end else if (valid) begin
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  p_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= CNT_W'(MAX_RUN));

  p_single_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid && fault && (fc_code == '0) |=> flag);

  p_pass_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !fault |=> !flag && (run_q == '0));

  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(flag) && $stable(run_q));
endmodule

// File: rtl/lcmp_ready_flag.sv
module lcmp_ready_flag
  import lcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic              cfg_rd,
  input  logic              cfg_wr,
  input  logic [MODE_W-1:0] cfg_wr_mode,
  output logic              ready
);
  logic ready_q, ready_d;
  logic clr_req;

  always_comb begin
    clr_req = cfg_rd || (cfg_wr && (cfg_wr_mode != MODE_OFF));
    ready_d = ready_q;
    if (conv_done)    ready_d = 1'b1;
    else if (clr_req) ready_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= ready_d;
  end

  assign ready = ready_q;

  p_done_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> ready);

  p_cfg_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done && (cfg_rd || (cfg_wr && cfg_wr_mode != MODE_OFF)) |=> !ready);

  p_quiet_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done && !cfg_rd && !(cfg_wr && cfg_wr_mode != MODE_OFF) |=> $stable(ready));
endmodule

// File: rtl/lcmp_limit_monitor.sv
module lcmp_limit_monitor
  import lcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        res_valid,
  input  logic [15:0] res_word,
  input  logic [15:0] lo_limit,
  input  logic [15:0] hi_limit,
  input  logic [1:0]  fault_cnt,
  input  logic        mask_exp,
  input  logic [3:0]  range_code,
  input  logic        cfg_rd,
  input  logic        cfg_wr,
  input  logic [1:0]  cfg_wr_mode,
  output logic [15:0] res_readback,
  output logic        flag_hi,
  output logic        flag_lo,
  output logic        conv_ready
);
  localparam int unsigned N_OPS   = 3;
  localparam int unsigned OP_RES  = 0;
  localparam int unsigned OP_HI   = 1;
  localparam int unsigned OP_LO   = 2;
  localparam int unsigned N_SIDES = 2;

  logic sys_rst_n;

  lcmp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_rst_n (sys_rst_n)
  );

  word_t op_word [N_OPS];
  lin_t  op_lin  [N_OPS];

  assign op_word[OP_RES] = res_word;
  assign op_word[OP_HI]  = hi_limit;
  assign op_word[OP_LO]  = lo_limit;

  for (genvar g = 0; g < N_OPS; g++) begin : g_lin
    lcmp_linearize u_lin (
      .word_in (op_word[g]),
      .lin_out (op_lin[g])
    );
  end

  logic [N_SIDES-1:0] side_fault;
  logic [N_SIDES-1:0] side_flag;

  always_comb begin
    side_fault[0] = op_lin[OP_RES] > op_lin[OP_HI];
    side_fault[1] = op_lin[OP_RES] < op_lin[OP_LO];
  end

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    lcmp_fault_track #(.CODE_W(FC_W)) u_track (
      .clk     (clk),
      .rst_n   (sys_rst_n),
      .valid   (res_valid),
      .fault   (side_fault[s]),
      .fc_code (fault_cnt),
      .flag    (side_flag[s])
    );
  end

  assign flag_hi = side_flag[0];
  assign flag_lo = side_flag[1];

  lcmp_ready_flag u_ready (
    .clk         (clk),
    .rst_n       (sys_rst_n),
    .conv_done   (res_valid),
    .cfg_rd      (cfg_rd),
    .cfg_wr      (cfg_wr),
    .cfg_wr_mode (cfg_wr_mode),
    .ready       (conv_ready)
  );

  logic  hide_exp;
  word_t rb_d, rb_q;

  always_comb begin
    hide_exp = mask_exp && (range_code < AUTO_RANGE);
    rb_d     = rb_q;
    if (res_valid) rb_d = hide_exp ? {{EXP_W{1'b0}}, res_word[MANT_W-1:0]} : res_word;
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)     rb_q <= '0;
    else if (res_valid) rb_q <= rb_d;
  end

  assign res_readback = rb_q;

  p_mask_zero_r6: assert property (@(posedge clk) disable iff (!sys_rst_n)
    res_valid && mask_exp && (range_code < 4'hC) |=>
      (res_readback[15:12] == 4'h0) && (res_readback[11:0] == $past(res_word[11:0])));

  p_no_mask_r6: assert property (@(posedge clk) disable iff (!sys_rst_n)
    res_valid && !(mask_exp && (range_code < 4'hC)) |=> res_readback == $past(res_word));

  p_hi_single_r2: assert property (@(posedge clk) disable iff (!sys_rst_n)
    res_valid && (fault_cnt == 2'b00) && (op_lin[OP_RES] > op_lin[OP_HI]) |=> flag_hi);

  p_lo_single_r3: assert property (@(posedge clk) disable iff (!sys_rst_n)
    res_valid && (fault_cnt == 2'b00) && (op_lin[OP_RES] < op_lin[OP_LO]) |=> flag_lo);

  p_idle_rb_r10: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !res_valid |=> $stable(res_readback));

  p_reset_quiet_r9: assert property (@(posedge clk)
    !sys_rst_n |-> !flag_hi && !flag_lo && !conv_ready && (res_readback == '0));
endmodule

// File: tb/lcmp_limit_monitor_test.sv
`timescale 1ns/1ps
module lcmp_limit_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        res_valid;
  logic [15:0] res_word;
  logic [15:0] lo_limit;
  logic [15:0] hi_limit;
  logic [1:0]  fault_cnt;
  logic        mask_exp;
  logic [3:0]  range_code;
  logic        cfg_rd;
  logic        cfg_wr;
  logic [1:0]  cfg_wr_mode;
  logic [15:0] res_readback;
  logic        flag_hi;
  logic        flag_lo;
  logic        conv_ready;

  always #2 clk = ~clk;

  lcmp_limit_monitor uut (
    .clk, .rst_n, .res_valid, .res_word, .lo_limit, .hi_limit, .fault_cnt,
    .mask_exp, .range_code, .cfg_rd, .cfg_wr, .cfg_wr_mode,
    .res_readback, .flag_hi, .flag_lo, .conv_ready
  );

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  int          m_run_hi, m_run_lo;
  logic        m_hi, m_lo, m_rdy;
  logic [15:0] m_rb;

  function automatic logic [22:0] lin_of(input logic [15:0] w);
    int e;
    e = w[15:12];
    if (e > 11) e = 11;
    return 23'(w[11:0]) << e;
  endfunction

  function automatic int need_of(input logic [1:0] c);
    case (c)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 4;
      default: return 8;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp_v);
    n_vec++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp_v, $time);
    end
  endtask

  task automatic chk_all(input string ctx);
    chk({ctx, " R6 readback"}, res_readback, m_rb);
    chk({ctx, " R2 R4 R5 flag_hi"}, 16'(flag_hi), 16'(m_hi));
    chk({ctx, " R3 R4 R5 flag_lo"}, 16'(flag_lo), 16'(m_lo));
    chk({ctx, " R7 R8 conv_ready"}, 16'(conv_ready), 16'(m_rdy));
  endtask

  task automatic model_result(input logic [15:0] w);
    if (lin_of(w) > lin_of(hi_limit)) begin
      if (m_run_hi < 8) m_run_hi++;
      m_hi = (m_run_hi >= need_of(fault_cnt));
    end else begin
      m_run_hi = 0; m_hi = 0;
    end
    if (lin_of(w) < lin_of(lo_limit)) begin
      if (m_run_lo < 8) m_run_lo++;
      m_lo = (m_run_lo >= need_of(fault_cnt));
    end else begin
      m_run_lo = 0; m_lo = 0;
    end
    m_rb  = (mask_exp && range_code < 4'hC) ? {4'h0, w[11:0]} : w;
    m_rdy = 1'b1;
  endtask

  task automatic put_result(input logic [15:0] w, input string ctx);
    @(negedge clk);
    res_word  = w;
    res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
    model_result(w);
    chk_all(ctx);
  endtask

  task automatic cfg_op(input logic rd, input logic wr, input logic [1:0] mode, input string ctx);
    @(negedge clk);
    cfg_rd = rd; cfg_wr = wr; cfg_wr_mode = mode;
    @(negedge clk);
    cfg_rd = 1'b0; cfg_wr = 1'b0; cfg_wr_mode = 2'b00;
    if (rd || (wr && mode != 2'b00)) m_rdy = 1'b0;
    chk({ctx, " R8 conv_ready"}, 16'(conv_ready), 16'(m_rdy));
  endtask

  task automatic set_limits(input logic [15:0] lo, input logic [15:0] hi, input logic [1:0] fc);
    @(negedge clk);
    lo_limit = lo; hi_limit = hi; fault_cnt = fc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    rst_n = 1'b0; res_valid = 1'b0; res_word = '0;
    lo_limit = 16'h0000; hi_limit = 16'hBFFF; fault_cnt = 2'b00;
    mask_exp = 1'b0; range_code = 4'hC;
    cfg_rd = 1'b0; cfg_wr = 1'b0; cfg_wr_mode = 2'b00;
    m_run_hi = 0; m_run_lo = 0; m_hi = 0; m_lo = 0; m_rdy = 0; m_rb = '0;

    repeat (3) @(negedge clk);
    chk_all("reset active R9");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_all("after reset R9");

    // R2: equal to high limit is not a fault; one above is, with fc 1
    set_limits(16'h0000, 16'h3456, 2'b00);
    put_result(16'h3456, "equal hi R2");
    put_result(16'h3457, "above hi R2");
    // R1: different exponents, same linear value (0x800<<8 == 0x100<<11)
    set_limits(16'h0000, 16'h8800, 2'b00);
    put_result(16'hB100, "same linear R1");
    put_result(16'h9401, "linear above R1");
    // R1: exponent 15 clamps to 11: 0xF001 == 0xB001
    set_limits(16'h0000, 16'hB001, 2'b00);
    put_result(16'hF001, "clamped exp R1");
    // R3: equal to low limit is not a fault; one below is
    set_limits(16'h7100, 16'hBFFF, 2'b00);
    put_result(16'h6200, "equal lo R1 R3");
    put_result(16'h61FF, "below lo R3");
    put_result(16'h7100, "back in R5");

    // R4: each persistence code, run of exactly need faults, broken run first
    for (int c = 0; c < 4; c++) begin
      set_limits(16'h0100, 16'h0800, 2'(c));
      put_result(16'h0400, "in range R5");
      for (int k = 0; k < need_of(2'(c)) - 1; k++) put_result(16'h0900, "run short R4");
      put_result(16'h0400, "break run R5");
      for (int k = 0; k < need_of(2'(c)); k++) put_result(16'h0900, "run full R4");
      put_result(16'h0A00, "run extra R4");
      for (int k = 0; k < need_of(2'(c)); k++) put_result(16'h0050, "low run R4");
    end

    // R10: idle cycles with changing inputs leave flags and readback alone
    set_limits(16'h0000, 16'h0010, 2'b00);
    put_result(16'h0020, "prep R10");
    @(negedge clk);
    res_word = 16'h0001; hi_limit = 16'hBFFF; lo_limit = 16'hBFFF; fault_cnt = 2'b11;
    repeat (3) @(negedge clk);
    chk_all("idle R10");

    // R6: masked readback, comparison on unmasked value
    set_limits(16'h0000, 16'h0010, 2'b00);
    mask_exp = 1'b1; range_code = 4'h3;
    put_result(16'h5001, "mask manual R6");
    range_code = 4'hC;
    put_result(16'h5001, "mask auto R6");
    range_code = 4'hB;
    put_result(16'h2ABC, "mask top manual R6");
    mask_exp = 1'b0;
    put_result(16'h2ABC, "no mask R6");

    // R7 / R8: ready flag
    cfg_op(1'b0, 1'b1, 2'b00, "wr mode off keeps R8");
    cfg_op(1'b0, 1'b1, 2'b10, "wr mode run clears R8");
    put_result(16'h0001, "ready set R7");
    cfg_op(1'b1, 1'b0, 2'b00, "rd clears R8");
    cfg_op(1'b0, 1'b1, 2'b00, "wr off when clear R8");
    put_result(16'h0001, "ready again R7");
    cfg_op(1'b0, 1'b1, 2'b01, "wr single clears R8");
    @(negedge clk);
    res_word = 16'h0002; res_valid = 1'b1; cfg_rd = 1'b1;
    @(negedge clk);
    res_valid = 1'b0; cfg_rd = 1'b0;
    model_result(16'h0002);
    chk_all("result beats clear R7");

    // Random results around random limits
    for (int blk = 0; blk < 40; blk++) begin
      logic [15:0] lo_r, hi_r;
      lo_r = {4'($urandom_range(0, 6)), 12'($urandom)};
      hi_r = {4'($urandom_range(3, 9)), 12'($urandom)};
      set_limits(lo_r, hi_r, 2'($urandom));
      mask_exp   = 1'($urandom);
      range_code = 4'($urandom);
      for (int k = 0; k < 12; k++) begin
        logic [15:0] w;
        w = {4'($urandom_range(0, 15)), 12'($urandom)};
        if (($urandom % 3) == 0) w = {hi_r[15:12] + 4'd1, 12'($urandom)};
        put_result(w, "random R1");
        if (($urandom % 5) == 0)
          cfg_op(1'($urandom), 1'($urandom), 2'($urandom), "random cfg R8");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule